// File: doc/BRIEF.md
# Bit-Addressed Logic Instruction Executor

This block runs a user program made of single-bit logic instructions. Each 16-bit instruction carries a 4-bit prefix and a 12-bit operand. The prefix chooses the operation, the target field and the polarity of a read. For data accesses the operand names one bit (upper nibble) of one word (lower byte). A one-bit accumulator picks up operands by loading, AND or OR. It is written back to any bit of a 128-word bus data field. It can also be written to a 128-word internal scratch field, as a plain store or as a set/reset latch action.

Composite function blocks are subroutines somewhere in the program ROM. Every accepted call, including a repeated call of the same subroutine, takes the next unused 4-word frame from a pool of 64. Inside a subroutine the scratch prefixes address that frame, word 0 to 3. Because call N always gets frame N, every call site keeps its own state from one execution cycle to the next.

A start pulse begins a cycle at line 0. The cycle ends on an end instruction, which pulses done. If the program runs past the selected length of 2048 or 4096 lines, the cycle stops with a length error instead. Outside a cycle the bus field is reachable word-wide through a simple port, so data can be exchanged with the rest of the system.

Top module: `bitlogic_exec`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, acc_o, call_err_o and len_err_o are 0, and every bus field word reads 0000.
- R2: Instruction format: bits [15:12] are the prefix, bits [11:8] the bit index and bits [6:0] the word address. The ROM returns the word for rom_addr_o one clock later. Each instruction takes two clocks, so a cycle of N instructions followed by the end instruction raises done_o on the 2N+2nd rising edge after the edge that samples start_i.
- R3: Prefix 4 reads a bus field bit true and prefix 5 reads it inverted into the accumulator. The accumulator changes only while a cycle runs and is cleared when a cycle starts.
- R4: Outside a subroutine, prefix 2 reads a scratch bit true, prefix 3 reads it inverted, and prefix A stores the accumulator into it. Scratch contents persist across cycles.
- R5: Prefixes 8 and B both store the accumulator into the addressed bus field bit. The other 15 bits of that word keep their values.
- R6: Prefix 7 sets the combine mode for the next read from operand bits [1:0]: 01 selects AND, 10 selects OR, 00 and 11 select load. After any read the mode is AND. After a store, set or reset the mode is load. Each cycle starts in load mode.
- R7: Prefix C sets the addressed scratch bit when the accumulator is 1. Prefix D clears it when the accumulator is 1. Neither changes anything when the accumulator is 0.
- R8: Prefix 1 calls the subroutine at the line given by operand bits [11:0] and takes frame k for the k-th accepted call of the cycle (k from 0). While in the subroutine, prefixes 2, 3, A, C and D address word operand[1:0] of that frame. Prefix 6 returns to the line after the call.
- R9: A 65th call in one cycle is not taken: execution continues on the next line and call_err_o goes to 1. call_err_o stays 1 until the next start. Exactly 64 calls leave it at 0.
- R10: Prefix 0 ends the cycle: done_o is 1 for exactly one clock and busy_o is 0 in that clock.
- R11: prog_long_i=0 limits the program to 2048 lines and prog_long_i=1 to 4096. Moving to a line at or past the limit stops the cycle with len_err_o=1 and no done_o pulse. A new start clears len_err_o.
- R12: While idle, bus_we_i writes bus_wdata_i to bus word bus_addr_i, and bus_rdata_o shows that word combinationally. While busy, bus_we_i is ignored.
- R13: Prefixes 9, E and F change neither the accumulator, its combine mode nor any stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an execution cycle (taken when idle) |
| prog_long_i | input | 1 | Program length select: 0 = 2048 lines, 1 = 4096 lines |
| rom_addr_o | output | 12 | Program ROM line address |
| rom_data_i | input | 16 | Program ROM word, one clock after the address |
| bus_we_i | input | 1 | Word write to the bus field (idle only) |
| bus_addr_i | input | 7 | Bus field word address for the external port |
| bus_wdata_i | input | 16 | Write data for the external port |
| bus_rdata_o | output | 16 | Bus field word at bus_addr_i (valid while idle) |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-clock pulse when the end instruction completes |
| acc_o | output | 1 | Accumulator value |
| call_err_o | output | 1 | More than 64 calls were made in this cycle |
| len_err_o | output | 1 | Program ran past the selected length |

## Verification
The assertions check on every cycle that done is a single-clock pulse seen only when idle, and that the line address stays under the selected length while busy. They also check that a length error always stops the cycle, that the accumulator holds still while idle, and that the call counter never passes 64, with its overflow flag sticky and cleared on start. Only the bench scenarios can show what each prefix computes: the polarity of reads, the combine modes and their reset rules, and set/reset behaviour with either accumulator value. The bench alone also shows that a store touches a single bit, that repeated calls of one subroutine get distinct, persistent frames, that a 65th call is skipped rather than taken, and that an external write during a cycle is dropped.

// File: rtl/ble_pkg.sv
package ble_pkg;
  localparam int INSTR_W = 16;
  localparam int ADDR_W  = 7;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EXEC} state_e;
  typedef enum logic [1:0] {M_LD, M_AND, M_OR} comb_e;
  typedef enum logic [3:0] {
    K_NOP, K_END, K_CALL, K_RET, K_MODE, K_READ, K_STORE, K_SET, K_CLR
  } kind_e;

  typedef struct packed {
    kind_e              kind;
    logic               to_bus;
    logic               inv;
    logic [3:0]         bit_idx;
    logic [ADDR_W-1:0]  addr;
    logic [11:0]        target;
  } instr_t;
endpackage

// File: rtl/ble_decode.sv
module ble_decode
  import ble_pkg::*;
(
  input  logic [INSTR_W-1:0] word_i,
  output instr_t             ins_o
);
  always_comb begin
    ins_o.kind    = K_NOP;
    ins_o.to_bus  = 1'b0;
    ins_o.inv     = 1'b0;
    ins_o.bit_idx = word_i[11:8];
    ins_o.addr    = word_i[ADDR_W-1:0];
    ins_o.target  = word_i[11:0];
    unique case (word_i[15:12])
      4'h0: ins_o.kind = K_END;
      4'h1: ins_o.kind = K_CALL;
      4'h2: ins_o.kind = K_READ;
      4'h3: begin ins_o.kind = K_READ; ins_o.inv = 1'b1; end
      4'h4: begin ins_o.kind = K_READ; ins_o.to_bus = 1'b1; end
      4'h5: begin ins_o.kind = K_READ; ins_o.to_bus = 1'b1; ins_o.inv = 1'b1; end
      4'h6: ins_o.kind = K_RET;
      4'h7: ins_o.kind = K_MODE;
      4'h8, 4'hB: begin ins_o.kind = K_STORE; ins_o.to_bus = 1'b1; end
      4'hA: ins_o.kind = K_STORE;
      4'hC: ins_o.kind = K_SET;
      4'hD: ins_o.kind = K_CLR;
      default: ins_o.kind = K_NOP;
    endcase
  end
endmodule

// File: rtl/ble_bitmem.sv
module ble_bitmem #(
  parameter int WORDS  = 128,
  parameter int DATA_W = 16,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_word_o,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_mask_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [DATA_W-1:0] mem_q [WORDS];

  assign rd_word_o = (int'(rd_addr_i) < WORDS) ? mem_q[rd_addr_i] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (wr_en_i && int'(wr_addr_i) < WORDS) begin
      mem_q[wr_addr_i] <= (mem_q[wr_addr_i] & ~wr_mask_i) | (wr_data_i & wr_mask_i);
    end
  end

  // frame and scratch addressing must land inside the array
  p_wr_in_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (int'(wr_addr_i) < WORDS));
endmodule

// File: rtl/ble_frame_alloc.sv
module ble_frame_alloc #(
  parameter int FRAMES = 64,
  localparam int FR_W  = $clog2(FRAMES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            call_i,
  input  logic            ret_i,
  output logic            accept_o,
  output logic            in_comp_o,
  output logic [FR_W-1:0] frame_o,
  output logic            overflow_o
);
  logic [FR_W:0] used_q;
  logic          full;

  assign full     = (int'(used_q) >= FRAMES);
  assign accept_o = call_i && !in_comp_o && !full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q     <= '0;
      in_comp_o  <= 1'b0;
      frame_o    <= '0;
      overflow_o <= 1'b0;
    end else if (clear_i) begin
      used_q     <= '0;
      in_comp_o  <= 1'b0;
      overflow_o <= 1'b0;
    end else begin
      if (accept_o) begin
        frame_o   <= used_q[FR_W-1:0];
        used_q    <= used_q + 1'b1;
        in_comp_o <= 1'b1;
      end else if (call_i && !in_comp_o && full) begin
        overflow_o <= 1'b1;
      end
      if (ret_i && in_comp_o) in_comp_o <= 1'b0;
    end
  end

  p_frame_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(used_q) <= FRAMES);
  p_overflow_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !clear_i) |=> overflow_o);
  p_accept_enter_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> (in_comp_o && frame_o == $past(used_q[FR_W-1:0])));
endmodule

// File: rtl/bitlogic_exec.sv
module bitlogic_exec
  import ble_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int BUS_WORDS   = 128,
  parameter int INT_WORDS   = 128,
  parameter int FRAMES      = 64,
  parameter int FRAME_WORDS = 4,
  parameter int PC_W        = 12,
  parameter int SHORT_LINES = 2048
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic                          prog_long_i,
  output logic [PC_W-1:0]               rom_addr_o,
  input  logic [INSTR_W-1:0]            rom_data_i,
  input  logic                          bus_we_i,
  input  logic [$clog2(BUS_WORDS)-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]             bus_wdata_i,
  output logic [DATA_W-1:0]             bus_rdata_o,
  output logic                          busy_o,
  output logic                          done_o,
  output logic                          acc_o,
  output logic                          call_err_o,
  output logic                          len_err_o
);
  localparam int BUS_AW     = $clog2(BUS_WORDS);
  localparam int INT_AW     = $clog2(INT_WORDS);
  localparam int SCR_WORDS  = INT_WORDS + FRAMES * FRAME_WORDS;
  localparam int SCR_AW     = $clog2(SCR_WORDS);
  localparam int FR_W       = $clog2(FRAMES);
  localparam int FW_W       = $clog2(FRAME_WORDS);
  localparam int BIT_W      = $clog2(DATA_W);
  localparam int LONG_LINES = 1 << PC_W;

  state_e            state_q;
  comb_e             mode_q;
  logic [PC_W-1:0]   pc_q;
  logic [PC_W:0]     ret_pc_q;
  logic              acc_q, done_q, len_err_q;
  instr_t            ins;
  logic              exec, start_ok;

  assign exec     = (state_q == S_EXEC);
  assign start_ok = (state_q == S_IDLE) && start_i;

  ble_decode u_dec (.word_i(rom_data_i), .ins_o(ins));

  // call frames
  logic            call_ok, in_comp, overflow;
  logic [FR_W-1:0] frame;

  ble_frame_alloc #(.FRAMES(FRAMES)) u_frames (
    .clk_i, .rst_ni,
    .clear_i   (start_ok),
    .call_i    (exec && ins.kind == K_CALL),
    .ret_i     (exec && ins.kind == K_RET),
    .accept_o  (call_ok),
    .in_comp_o (in_comp),
    .frame_o   (frame),
    .overflow_o(overflow)
  );

  // operand addressing
  logic [BIT_W-1:0]  bit_sel;
  logic [DATA_W-1:0] bit_mask;
  logic [SCR_AW-1:0] scr_addr;
  logic [BUS_AW-1:0] bus_rd_addr;

  assign bit_sel     = ins.bit_idx[BIT_W-1:0];
  assign bit_mask    = DATA_W'(1) << bit_sel;
  assign bus_rd_addr = exec ? ins.addr[BUS_AW-1:0] : bus_addr_i;

  always_comb begin
    if (in_comp) scr_addr = SCR_AW'(INT_WORDS) + SCR_AW'({frame, ins.addr[FW_W-1:0]});
    else         scr_addr = SCR_AW'(ins.addr[INT_AW-1:0]);
  end

  // field storage
  logic [DATA_W-1:0] bus_word, scr_word, bus_wmask, bus_wdata, scr_wdata;
  logic [BUS_AW-1:0] bus_waddr;
  logic              bus_wen, scr_wen;

  always_comb begin
    bus_wen   = 1'b0;
    bus_waddr = bus_addr_i;
    bus_wmask = '1;
    bus_wdata = bus_wdata_i;
    if (exec) begin
      if (ins.kind == K_STORE && ins.to_bus) begin
        bus_wen   = 1'b1;
        bus_waddr = ins.addr[BUS_AW-1:0];
        bus_wmask = bit_mask;
        bus_wdata = {DATA_W{acc_q}};
      end
    end else if (state_q == S_IDLE && bus_we_i) begin
      bus_wen = 1'b1;
    end
  end

  always_comb begin
    scr_wen   = 1'b0;
    scr_wdata = '0;
    if (exec && !ins.to_bus) begin
      unique case (ins.kind)
        K_STORE: begin scr_wen = 1'b1;  scr_wdata = {DATA_W{acc_q}}; end
        K_SET:   begin scr_wen = acc_q; scr_wdata = '1; end
        K_CLR:   begin scr_wen = acc_q; scr_wdata = '0; end
        default: ;
      endcase
    end
  end

  ble_bitmem #(.WORDS(BUS_WORDS), .DATA_W(DATA_W)) u_bus_field (
    .clk_i, .rst_ni,
    .rd_addr_i(bus_rd_addr), .rd_word_o(bus_word),
    .wr_en_i(bus_wen), .wr_addr_i(bus_waddr),
    .wr_mask_i(bus_wmask), .wr_data_i(bus_wdata)
  );

  ble_bitmem #(.WORDS(SCR_WORDS), .DATA_W(DATA_W)) u_scratch (
    .clk_i, .rst_ni,
    .rd_addr_i(scr_addr), .rd_word_o(scr_word),
    .wr_en_i(scr_wen), .wr_addr_i(scr_addr),
    .wr_mask_i(bit_mask), .wr_data_i(scr_wdata)
  );

  // operand and accumulator update
  logic opnd, acc_nxt;
  assign opnd = (ins.to_bus ? bus_word[bit_sel] : scr_word[bit_sel]) ^ ins.inv;

  always_comb begin
    unique case (mode_q)
      M_AND:   acc_nxt = acc_q & opnd;
      M_OR:    acc_nxt = acc_q | opnd;
      default: acc_nxt = opnd;
    endcase
  end

  // sequencing
  logic [PC_W:0] lim, nxt_pc;
  assign lim = prog_long_i ? (PC_W+1)'(LONG_LINES) : (PC_W+1)'(SHORT_LINES);

  always_comb begin
    nxt_pc = {1'b0, pc_q} + 1'b1;
    if (ins.kind == K_CALL && call_ok)     nxt_pc = {1'b0, ins.target};
    else if (ins.kind == K_RET && in_comp) nxt_pc = ret_pc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      mode_q    <= M_LD;
      pc_q      <= '0;
      ret_pc_q  <= '0;
      acc_q     <= 1'b0;
      done_q    <= 1'b0;
      len_err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          pc_q      <= '0;
          acc_q     <= 1'b0;
          mode_q    <= M_LD;
          len_err_q <= 1'b0;
          state_q   <= S_FETCH;
        end
        S_FETCH: state_q <= S_EXEC;
        default: begin
          unique case (ins.kind)
            K_READ: begin acc_q <= acc_nxt; mode_q <= M_AND; end
            K_STORE, K_SET, K_CLR: mode_q <= M_LD;
            K_MODE: begin
              unique case (ins.addr[1:0])
                2'b01:   mode_q <= M_AND;
                2'b10:   mode_q <= M_OR;
                default: mode_q <= M_LD;
              endcase
            end
            K_CALL: if (call_ok) ret_pc_q <= {1'b0, pc_q} + 1'b1;
            default: ;
          endcase
          if (ins.kind == K_END) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
          end else if (nxt_pc >= lim) begin
            state_q   <= S_IDLE;
            len_err_q <= 1'b1;
          end else begin
            pc_q    <= nxt_pc[PC_W-1:0];
            state_q <= S_FETCH;
          end
        end
      endcase
    end
  end

  assign rom_addr_o  = pc_q;
  assign bus_rdata_o = bus_word;
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = done_q;
  assign acc_o       = acc_q;
  assign call_err_o  = overflow;
  assign len_err_o   = len_err_q;

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_pc_range_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ({1'b0, rom_addr_o} < lim));
  p_len_stop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(len_err_o) |-> (!busy_o && !done_o));
  p_acc_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(acc_o));
  p_start_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && !call_err_o && !len_err_o));
endmodule

// File: tb/tb_bitlogic_exec.sv
`timescale 1ns/1ps
module tb_bitlogic_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        prog_long = 1'b1;
  logic [11:0] rom_addr;
  logic [15:0] rom_q;
  logic        bus_we = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        busy, done, acc, call_err, len_err;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  logic [15:0] rom [4096];
  always_ff @(posedge clk) rom_q <= rom[rom_addr];

  bitlogic_exec dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .prog_long_i(prog_long),
    .rom_addr_o(rom_addr), .rom_data_i(rom_q),
    .bus_we_i(bus_we), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .busy_o(busy), .done_o(done), .acc_o(acc),
    .call_err_o(call_err), .len_err_o(len_err)
  );

  // {i0, i1, i2, i3, expected word 7F, expected acc}; w00=A5C3, w01=0F0F, w7F=00F0 before each
  localparam logic [95:0] VEC [11] = '{
    {16'h4000, 16'h807F, 16'h9000, 16'h9000, 16'h00F1, 16'h0001}, // R3 R5 true read
    {16'h4100, 16'h5200, 16'hB37F, 16'h9000, 16'h00F8, 16'h0001}, // R3 inverted, R5 prefix B
    {16'h4200, 16'h7002, 16'h4301, 16'h8F7F, 16'h80F0, 16'h0001}, // R6 OR
    {16'h4000, 16'h4401, 16'h857F, 16'h9000, 16'h00D0, 16'h0000}, // R6 AND, R5 clear one bit
    {16'h4D00, 16'hA32A, 16'h332A, 16'h867F, 16'h00B0, 16'h0000}, // R4 store and inverted read
    {16'h232A, 16'h7000, 16'h4200, 16'h8A7F, 16'h00F0, 16'h0000}, // R4 persist, R6 load
    {16'h4000, 16'hC52A, 16'h252A, 16'h8C7F, 16'h10F0, 16'h0001}, // R7 set
    {16'h4200, 16'hD52A, 16'h252A, 16'h807F, 16'h00F1, 16'h0001}, // R7 reset with acc 0
    {16'h4000, 16'hD52A, 16'h252A, 16'h847F, 16'h00E0, 16'h0000}, // R7 reset with acc 1
    {16'h4000, 16'hE123, 16'hF456, 16'h827F, 16'h00F4, 16'h0001}, // R13 no-ops
    {16'h5000, 16'h7002, 16'h5201, 16'h817F, 16'h00F0, 16'h0000}  // R3 R6 inverted OR
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rom_clear();
    for (int i = 0; i < 4096; i++) rom[i] = 16'h9000;
  endtask

  task automatic bus_write(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [6:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic run_prog(output logic seen_done, output int cnt);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    seen_done = 1'b0;
    while (busy) begin
      @(negedge clk);
      cnt++;
      if (cnt > 20000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        break;
      end
    end
    seen_done = done;
  endtask

  initial begin
    logic [15:0] rd;
    logic        sd;
    int          cnt;

    rom_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 acc", acc, 0);
    check("R1 call_err", call_err, 0);
    check("R1 len_err", len_err, 0);
    bus_read(7'h33, rd);
    check("R1 bus word", rd, 16'h0000);

    // vector table
    foreach (VEC[v]) begin
      rom[0] = VEC[v][95:80]; rom[1] = VEC[v][79:64];
      rom[2] = VEC[v][63:48]; rom[3] = VEC[v][47:32];
      rom[4] = 16'h0000;
      bus_write(7'h00, 16'hA5C3);
      bus_write(7'h01, 16'h0F0F);
      bus_write(7'h7F, 16'h00F0);
      run_prog(sd, cnt);
      check($sformatf("R10 vec%0d done", v), sd, 1);
      bus_read(7'h7F, rd);
      check($sformatf("R5 vec%0d word", v), rd, VEC[v][31:16]);
      check($sformatf("R3 vec%0d acc", v), acc, VEC[v][0]);
    end

    // R2 timing: 3 no-ops then end
    rom_clear();
    rom[3] = 16'h0000;
    run_prog(sd, cnt);
    check("R2 edges to done", cnt, 9);
    check("R10 done seen", sd, 1);
    @(negedge clk);
    check("R10 done one clock", done, 0);

    // R8 distinct, persistent frames for repeated calls
    rom_clear();
    rom[0] = 16'h4000; rom[1] = 16'h1100; rom[2] = 16'h817F; rom[3] = 16'h4101;
    rom[4] = 16'h1100; rom[5] = 16'h827F; rom[6] = 16'h2000; rom[7] = 16'h837F;
    rom[8] = 16'h0000;
    rom[12'h100] = 16'h7000; rom[12'h101] = 16'h3000;
    rom[12'h102] = 16'hA000; rom[12'h103] = 16'h6000;
    bus_write(7'h7F, 16'h0000);
    run_prog(sd, cnt);
    check("R8 calls done", sd, 1);
    bus_read(7'h7F, rd);
    check("R8 first cycle frames", rd, 16'h0006);
    bus_write(7'h7F, 16'h000F);
    run_prog(sd, cnt);
    bus_read(7'h7F, rd);
    check("R8 frames persist", rd, 16'h0001);

    // R9 exactly 64 calls
    rom_clear();
    for (int i = 0; i < 64; i++) rom[i] = 16'h1200;
    rom[64] = 16'h0000;
    rom[12'h200] = 16'h837F; rom[12'h201] = 16'h6000;
    run_prog(sd, cnt);
    check("R9 64 calls done", sd, 1);
    check("R9 64 calls no error", call_err, 0);

    // R9 65th call skipped
    rom[64] = 16'h4000; rom[65] = 16'h1200; rom[66] = 16'h0000;
    bus_write(7'h7F, 16'h0000);
    run_prog(sd, cnt);
    check("R9 overflow done", sd, 1);
    check("R9 overflow flag", call_err, 1);
    bus_read(7'h7F, rd);
    check("R9 extra call ignored", rd, 16'h0000);

    // R11 length limits
    rom_clear();
    rom[2048] = 16'h0000;
    prog_long = 1'b0;
    run_prog(sd, cnt);
    check("R11 short overrun flag", len_err, 1);
    check("R11 short no done", sd, 0);
    check("R9 start clears call_err", call_err, 0);
    prog_long = 1'b1;
    run_prog(sd, cnt);
    check("R11 long reaches end", sd, 1);
    check("R11 start clears len_err", len_err, 0);
    rom[2048] = 16'h9000;
    run_prog(sd, cnt);
    check("R11 long overrun flag", len_err, 1);
    check("R11 long no done", sd, 0);

    // R12 external port
    bus_write(7'h50, 16'h1111);
    bus_read(7'h50, rd);
    check("R12 idle write", rd, 16'h1111);
    rom_clear();
    rom[10] = 16'h0000;
    fork
      run_prog(sd, cnt);
      begin
        @(negedge clk);
        @(negedge clk);
        bus_addr = 7'h50; bus_wdata = 16'hBEEF; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
      end
    join
    bus_read(7'h50, rd);
    check("R12 busy write ignored", rd, 16'h1111);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule